// File: doc/BRIEF.md
# Transceiver Reset Initialization Sequencer

This block brings up one direction (receive or transmit) of a multi-gigabit serial transceiver together with the shared PLL that supplies its serial clock. It runs on a free-running control clock of fixed frequency. After a power-up delay it puts the PLL and the channel into reset. It then releases them in a fixed order. The PLL reset is released once the reference clock is stable. The channel reset is released once the PLL reports lock. Initialization is complete when the channel reports that its reset has finished.

Each wait step has a timeout. Every timeout uses up one retry. When the retries are used up, the block parks in a failure state. The surrounding logic can rerun the whole sequence with a full request. It can also reset only the channel with a channel request. Status inputs from other clock domains pass through two-flop synchronizers. A user-ready flag in the user clock domain follows the release of the channel reset after a fixed delay.

Top module: `xrst_init_seq`

## Requirements
- R1: While `rst_n` is low, all five outputs are 0. After `rst_n` rises, both resets stay low for POR_CYC control cycles. Both then rise in the same cycle, at the POR_CYC-th rising edge after release. Requests are ignored during this wait.
- R2: `pll_rst_o` stays high while the synchronized reference-clock-stable status is low. After `refclk_ok_i` rises, `pll_rst_o` falls at the third rising edge (two synchronizer stages plus one state register). `chan_rst_o` stays high at that point.
- R3: `chan_rst_o` is released only after PLL lock is seen. It falls at the third rising edge after `pll_lock_i` rises.
- R4: `init_done_o` rises at the third rising edge after `chan_rst_done_i` rises while the channel reset is released. `init_done_o` is 0 before that.
- R5: A wait step whose condition stays false times out at its TMO_CYC-th cycle. It then spends one cycle in a timeout state. A full sequence resumes at the PLL step. A channel-only sequence resumes at the lock step.
- R6: After MAX_RETRY timeouts since the last request, `init_fail_o` rises. It then stays high, with `chan_rst_o` high and `pll_rst_o` low, whatever the status inputs do. Only a request clears it, and the request also clears the retry count.
- R7: `usr_ready_o` is low while the channel is held in reset. It rises 2 + READY_DLY `usr_clk` cycles after `chan_rst_o` falls: two synchronizer stages, then READY_DLY counted cycles.
- R8: A full request makes both resets high in the next cycle and reruns the whole sequence. A drop of `refclk_ok_i` alone, after completion, never raises `pll_rst_o` and leaves `init_done_o` high.
- R9: A channel request made while idle (done or failed) raises only `chan_rst_o`. It keeps `pll_rst_o` low. It holds `chan_rst_o` high until PLL lock is seen.
- R10: A request that arrives while a full sequence is busy restarts it from the PLL step. This applies to a channel request too, which is promoted to a full restart in that case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running control clock |
| rst_n | input | 1 | Active-low synchronous power-up reset |
| usr_clk | input | 1 | Channel user clock, for the ready flag |
| full_req_i | input | 1 | Request: reset the PLL and the channel (control domain) |
| chan_req_i | input | 1 | Request: reset the channel only (control domain) |
| refclk_ok_i | input | 1 | Reference clock stable (asynchronous) |
| pll_lock_i | input | 1 | PLL locked (asynchronous) |
| chan_rst_done_i | input | 1 | Channel reset finished (asynchronous) |
| pll_rst_o | output | 1 | PLL reset |
| chan_rst_o | output | 1 | Channel reset |
| usr_ready_o | output | 1 | User-ready flag, in the `usr_clk` domain |
| init_done_o | output | 1 | Initialization complete |
| init_fail_o | output | 1 | Retries exhausted |

## Verification
The hardest state to reach is the failure state entered from each of the three wait steps. Reaching it needs one status held low across MAX_RETRY full timeout loops, while the earlier steps pass every time the sequence resumes. The bench sweeps the step that is withheld. For each one it holds the other two status inputs high, fires a full request, and counts cycles to the failure flag against a closed-form loop-length formula. It also brings about the channel-only request with lock lost, and a channel request landing in the middle of a full sequence. It does this by dropping lock ahead of the request.

// File: rtl/xrst_pkg.sv
package xrst_pkg;

    typedef enum logic [2:0] {
        S_POR   = 3'd0,
        S_WREF  = 3'd1,
        S_WLOCK = 3'd2,
        S_WDONE = 3'd3,
        S_TMO   = 3'd4,
        S_DONE  = 3'd5,
        S_FAIL  = 3'd6
    } seq_st_e;

endpackage

// File: rtl/xrst_sync.sv
module xrst_sync #(
    parameter int   WIDTH   = 1,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stg_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stg_q[g] <= {WIDTH{RST_VAL}};
            end else begin
                stg_q[g] <= (g == 0) ? d_i : stg_q[(g == 0) ? 0 : g - 1];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/xrst_ready_gen.sv
module xrst_ready_gen #(
    parameter int READY_DLY   = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic usr_clk,
    input  logic rst_n,
    input  logic hold_i,
    output logic ready_o
);

    localparam int CNT_W = $clog2(READY_DLY + 1);

    logic             hold_s;
    logic [CNT_W-1:0] cnt_d, cnt_q;

    xrst_sync #(
        .WIDTH   (1),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_hold_sync (
        .clk   (usr_clk),
        .rst_n (rst_n),
        .d_i   (hold_i),
        .q_o   (hold_s)
    );

    always_comb begin
        cnt_d = cnt_q;
        if (hold_s) begin
            cnt_d = '0;
        end else if (cnt_q != CNT_W'(READY_DLY)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge usr_clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign ready_o = (cnt_q == CNT_W'(READY_DLY));

    AST_READY_HELD: assert property (@(posedge usr_clk) disable iff (!rst_n)
        hold_s |=> !ready_o);  // R7

endmodule

// File: rtl/xrst_seq_fsm.sv
module xrst_seq_fsm
    import xrst_pkg::*;
#(
    parameter int POR_CYC   = 64,
    parameter int TMO_CYC   = 100000,
    parameter int MAX_RETRY = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic full_req_i,
    input  logic chan_req_i,
    input  logic refclk_s_i,
    input  logic lock_s_i,
    input  logic rdone_s_i,
    output logic pll_rst_o,
    output logic chan_rst_o,
    output logic hold_o,
    output logic done_o,
    output logic fail_o
);

    localparam int CNT_MAX = (POR_CYC > TMO_CYC) ? POR_CYC : TMO_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int RTY_W   = $clog2(MAX_RETRY + 1);
    localparam logic [CNT_W-1:0] POR_LAST = CNT_W'(POR_CYC - 1);
    localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TMO_CYC - 1);
    localparam logic [RTY_W-1:0] RTY_LAST = RTY_W'(MAX_RETRY - 1);

    typedef struct packed {
        seq_st_e          st;
        logic [CNT_W-1:0] cnt;
        logic [RTY_W-1:0] rty;
        logic             full;
        logic             pll_rst;
        logic             chan_rst;
        logic             hold;
        logic             done;
        logic             fail;
    } seq_regs_t;

    seq_regs_t d, q;
    logic      busy_full;

    always_comb begin
        d         = q;
        d.cnt     = q.cnt + 1'b1;
        busy_full = q.full && !(q.st inside {S_DONE, S_FAIL});

        unique case (q.st)
            S_POR: begin
                if (q.cnt == POR_LAST) begin
                    d.st   = S_WREF;
                    d.cnt  = '0;
                    d.full = 1'b1;
                end
            end
            S_WREF: begin
                if (refclk_s_i) begin
                    d.st  = S_WLOCK;
                    d.cnt = '0;
                end else if (q.cnt == TMO_LAST) begin
                    d.st  = S_TMO;
                    d.cnt = '0;
                end
            end
            S_WLOCK: begin
                if (lock_s_i) begin
                    d.st  = S_WDONE;
                    d.cnt = '0;
                end else if (q.cnt == TMO_LAST) begin
                    d.st  = S_TMO;
                    d.cnt = '0;
                end
            end
            S_WDONE: begin
                if (rdone_s_i) begin
                    d.st  = S_DONE;
                    d.cnt = '0;
                end else if (q.cnt == TMO_LAST) begin
                    d.st  = S_TMO;
                    d.cnt = '0;
                end
            end
            S_TMO: begin
                d.cnt = '0;
                if (q.rty == RTY_LAST) begin
                    d.st = S_FAIL;
                end else begin
                    d.rty = q.rty + 1'b1;
                    d.st  = q.full ? S_WREF : S_WLOCK;
                end
            end
            S_DONE, S_FAIL: begin
                d.cnt = q.cnt;
            end
            default: begin
                d.st  = S_POR;
                d.cnt = '0;
            end
        endcase

        if (q.st != S_POR) begin
            if (full_req_i || (chan_req_i && busy_full)) begin
                d.st   = S_WREF;
                d.full = 1'b1;
                d.rty  = '0;
                d.cnt  = '0;
            end else if (chan_req_i) begin
                d.st   = S_WLOCK;
                d.full = 1'b0;
                d.rty  = '0;
                d.cnt  = '0;
            end
        end

        d.pll_rst  = (d.st == S_WREF) || ((d.st == S_TMO) && d.full);
        d.chan_rst = d.st inside {S_WREF, S_WLOCK, S_TMO, S_FAIL};
        d.hold     = d.chan_rst || (d.st == S_POR);
        d.done     = (d.st == S_DONE);
        d.fail     = (d.st == S_FAIL);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q          <= '0;
            q.st       <= S_POR;
            q.hold     <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign pll_rst_o  = q.pll_rst;
    assign chan_rst_o = q.chan_rst;
    assign hold_o     = q.hold;
    assign done_o     = q.done;
    assign fail_o     = q.fail;

    AST_PLL_WITH_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
        pll_rst_o |-> chan_rst_o);  // R1
    AST_PLL_REL_REFCLK: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pll_rst_o) && !fail_o) |-> $past(refclk_s_i));  // R2
    AST_CHAN_REL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chan_rst_o) |-> $past(lock_s_i));  // R3
    AST_DONE_AFTER_RDONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(rdone_s_i));  // R4
    AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st inside {S_WREF, S_WLOCK, S_WDONE}) |-> (q.cnt < CNT_W'(TMO_CYC)));  // R5
    AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.rty < RTY_W'(MAX_RETRY));  // R6
    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && !full_req_i && !chan_req_i) |=> fail_o);  // R6
    AST_CHANREQ_NO_PLL: assert property (@(posedge clk) disable iff (!rst_n)
        ((done_o || fail_o) && chan_req_i && !full_req_i) |=> (!pll_rst_o && chan_rst_o));  // R9
    AST_FULLREQ_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        (full_req_i && (q.st != S_POR)) |=> (pll_rst_o && chan_rst_o));  // R8

endmodule

// File: rtl/xrst_init_seq.sv
module xrst_init_seq #(
    parameter int POR_CYC     = 64,
    parameter int TMO_CYC     = 100000,
    parameter int MAX_RETRY   = 8,
    parameter int READY_DLY   = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic usr_clk,
    input  logic full_req_i,
    input  logic chan_req_i,
    input  logic refclk_ok_i,
    input  logic pll_lock_i,
    input  logic chan_rst_done_i,
    output logic pll_rst_o,
    output logic chan_rst_o,
    output logic usr_ready_o,
    output logic init_done_o,
    output logic init_fail_o
);

    localparam int N_STATUS = 3;

    logic [N_STATUS-1:0] status_raw, status_s;
    logic                hold;

    assign status_raw = {chan_rst_done_i, pll_lock_i, refclk_ok_i};

    xrst_sync #(
        .WIDTH   (N_STATUS),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b0)
    ) u_status_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (status_raw),
        .q_o   (status_s)
    );

    xrst_seq_fsm #(
        .POR_CYC   (POR_CYC),
        .TMO_CYC   (TMO_CYC),
        .MAX_RETRY (MAX_RETRY)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .full_req_i (full_req_i),
        .chan_req_i (chan_req_i),
        .refclk_s_i (status_s[0]),
        .lock_s_i   (status_s[1]),
        .rdone_s_i  (status_s[2]),
        .pll_rst_o  (pll_rst_o),
        .chan_rst_o (chan_rst_o),
        .hold_o     (hold),
        .done_o     (init_done_o),
        .fail_o     (init_fail_o)
    );

    xrst_ready_gen #(
        .READY_DLY   (READY_DLY),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_ready (
        .usr_clk (usr_clk),
        .rst_n   (rst_n),
        .hold_i  (hold),
        .ready_o (usr_ready_o)
    );

endmodule

// File: tb/xrst_init_seq_bench.sv
module xrst_init_seq_bench;

    localparam int POR   = 6;
    localparam int TMO   = 16;
    localparam int RETRY = 3;
    localparam int RDY   = 5;
    localparam int SYNC  = 2;

    logic clk = 1'b0;
    logic rst_n, full_req, chan_req, refclk_ok, pll_lock, rst_done;
    logic pll_rst, chan_rst, usr_ready, done, fail;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    xrst_init_seq #(
        .POR_CYC     (POR),
        .TMO_CYC     (TMO),
        .MAX_RETRY   (RETRY),
        .READY_DLY   (RDY),
        .SYNC_STAGES (SYNC)
    ) u_xrst_init_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .usr_clk         (clk),
        .full_req_i      (full_req),
        .chan_req_i      (chan_req),
        .refclk_ok_i     (refclk_ok),
        .pll_lock_i      (pll_lock),
        .chan_rst_done_i (rst_done),
        .pll_rst_o       (pll_rst),
        .chan_rst_o      (chan_rst),
        .usr_ready_o     (usr_ready),
        .init_done_o     (done),
        .init_fail_o     (fail)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse_full();
        full_req = 1'b1;
        tick(1);
        full_req = 1'b0;
    endtask

    task automatic pulse_chan();
        chan_req = 1'b1;
        tick(1);
        chan_req = 1'b0;
    endtask

    initial begin
        #(4ns * 100000);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int n;
        bit bad;
        rst_n = 1'b0; full_req = 1'b0; chan_req = 1'b0;
        refclk_ok = 1'b0; pll_lock = 1'b0; rst_done = 1'b0;
        tick(4);
        // R1: reset state
        chk("R1 pll_rst in reset", pll_rst, 0);
        chk("R1 chan_rst in reset", chan_rst, 0);
        chk("R1 ready in reset", usr_ready, 0);
        chk("R1 done in reset", done, 0);
        chk("R1 fail in reset", fail, 0);

        // R1: power-up delay then both resets together
        rst_n = 1'b1;
        n = 0;
        do begin tick(1); n++; end while (!pll_rst && n < 100);
        chk("R1 cycles to reset assertion", n, POR);
        chk("R1 chan_rst with pll_rst", chan_rst, 1);

        // R2: pll held while refclk low, then 2 sync + 1 latency
        tick(5);
        chk("R2 pll held without refclk", pll_rst, 1);
        refclk_ok = 1'b1;
        tick(SYNC);
        chk("R2 pll still held", pll_rst, 1);
        tick(1);
        chk("R2 pll released", pll_rst, 0);
        chk("R2 chan still held", chan_rst, 1);

        // R3: channel released after lock
        pll_lock = 1'b1;
        tick(SYNC);
        chk("R3 chan still held", chan_rst, 1);
        tick(1);
        chk("R3 chan released", chan_rst, 0);
        chk("R7 ready low at release", usr_ready, 0);

        // R7: ready delay
        n = 0;
        do begin tick(1); n++; end while (!usr_ready && n < 50);
        chk("R7 cycles to ready", n, SYNC + RDY);

        // R4: done after reset-done
        chk("R4 done low before reset-done", done, 0);
        rst_done = 1'b1;
        tick(SYNC);
        chk("R4 done not yet", done, 0);
        tick(1);
        chk("R4 done raised", done, 1);

        // R8: refclk drop alone has no effect
        refclk_ok = 1'b0;
        bad = 1'b0;
        for (int i = 0; i < 20; i++) begin
            tick(1);
            if (pll_rst || !done) bad = 1'b1;
        end
        chk("R8 refclk drop ignored", bad, 0);
        refclk_ok = 1'b1;
        tick(SYNC + 1);
        pulse_full();
        chk("R8 full req pll_rst", pll_rst, 1);
        chk("R8 full req chan_rst", chan_rst, 1);
        chk("R8 full req clears done", done, 0);
        tick(3);
        chk("R8 rerun completes", done, 1);
        chk("R8 rerun pll released", pll_rst, 0);

        // R9: channel-only request with lock lost
        pll_lock = 1'b0;
        tick(SYNC + 1);
        pulse_chan();
        chk("R9 chan_rst raised", chan_rst, 1);
        chk("R9 pll_rst untouched", pll_rst, 0);
        bad = 1'b0;
        for (int i = 0; i < 8; i++) begin
            tick(1);
            if (pll_rst || !chan_rst) bad = 1'b1;
        end
        chk("R9 held until lock, pll low", bad, 0);
        chk("R7 ready low while channel held", usr_ready, 0);
        pll_lock = 1'b1;
        tick(SYNC);
        chk("R9 chan held before lock seen", chan_rst, 1);
        tick(1);
        chk("R9 chan released after lock", chan_rst, 0);
        tick(1);
        chk("R9 done after channel reset", done, 1);

        // R10: restart while a full sequence is busy
        pll_lock = 1'b0;
        tick(SYNC + 1);
        pulse_full();
        tick(4);
        chk("R10 stuck in lock wait pll", pll_rst, 0);
        chk("R10 stuck in lock wait chan", chan_rst, 1);
        pulse_full();
        chk("R10 full req restarts PLL step", pll_rst, 1);
        tick(4);
        chk("R10 back in lock wait", pll_rst, 0);
        pulse_chan();
        chk("R10 chan req promoted to full", pll_rst, 1);

        // R5/R6: sweep the withheld step, count cycles to failure
        for (int s = 0; s < 3; s++) begin
            int exp_n;
            refclk_ok = (s != 0);
            pll_lock  = (s != 1);
            rst_done  = (s != 2);
            tick(SYNC + 2);
            exp_n = s + (RETRY - 1) * (TMO + 1 + s) + TMO + 2;
            full_req = 1'b1;
            n = 0;
            do begin
                tick(1);
                n++;
                if (n == 1) full_req = 1'b0;
            end while (!fail && n < 1000);
            chk($sformatf("R5 cycles to fail, step %0d", s), n, exp_n);
            chk($sformatf("R6 done low on fail, step %0d", s), done, 0);
            refclk_ok = 1'b1; pll_lock = 1'b1; rst_done = 1'b1;
            tick(12);
            chk($sformatf("R6 fail sticky, step %0d", s), fail, 1);
            chk($sformatf("R6 chan held in fail, step %0d", s), chan_rst, 1);
            chk($sformatf("R6 pll low in fail, step %0d", s), pll_rst, 0);
        end

        // R6: request clears failure
        pulse_full();
        chk("R6 request clears fail", fail, 0);
        tick(3);
        chk("R6 sequence completes after fail", done, 1);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

endmodule